// File: doc/BRIEF.md
# Descriptor Ring Doorbell Queue Controller

This block holds the pointer state of a single outbound descriptor ring. Software sets up the ring through a small write port: a base address, aligned to 64 bytes, and a length counted in descriptors. It then posts work by writing a count to a doorbell register. The tail moves forward only by those additive doorbell writes. The head moves forward by one each time the fetch side accepts a descriptor. A current pointer records the index of the descriptor most recently handed out for execution.

While the queue is enabled and holds pending descriptors, the controller raises a fetch request. The request carries the byte address of the next descriptor, which is the base plus the head times 16. Each fetched descriptor returns its first 32-bit word with the acknowledge. A 2-bit wrap tag inside that word is compared with the generation the queue expects, and that generation advances every time the head wraps. A mismatch sets a sticky ring-identity error. Software can clear the tail, the head and the current pointer independently through a soft-control register. A doorbell that would overfill the ring is dropped and flagged.

Top module: `dring_ctrl`

## Requirements
- R1: A write to the doorbell register (address 4, count in data bits [23:0]) moves the tail forward by that count, wrapping at the ring length. A count of 0 changes nothing.
- R2: The base low register (address 2'b01 → address 1) keeps data bits [31:6] and forces address bits [5:0] to zero. Address 2 supplies address bits [63:32]. `fetch_addr` equals base + head × 16 at all times.
- R3: A doorbell whose count plus the current pending count exceeds the ring length is ignored and leaves the tail unchanged. It also sets the sticky `err_db_ovf` flag.
- R4: `fetch_req` is high exactly when config register (address 0) bit 16 (prefetch enable) and bit 17 (scheduling enable) are both 1 and the pending count is nonzero.
- R5: A cycle with `fetch_ack` and `fetch_req` both high moves the head forward by one, wrapping to 0 at the ring length, and loads `curr_ptr` with the old head. `fetch_ack` while `fetch_req` is low has no effect.
- R6: `pend_cnt` is (tail − head) mod length, except that it equals the length when the ring is full. `q_full` is high when the pending count equals a nonzero ring length. The ring length is set at address 3, data bits [23:0].
- R7: The expected generation `exp_gen` starts at 0 and increments modulo 4 each time the head wraps. On an accepted fetch, bits [25:24] of `fetch_word0` (bits [1:0] of byte 3) that differ from `exp_gen` set the sticky `err_ring_id` flag.
- R8: A write to the soft-control register (address 5) with bit 1 set clears the tail, bit 2 clears the head and resets `exp_gen` to 0, and bit 3 clears `curr_ptr`. Each clear wins over an accept in the same cycle. After a tail or head clear, the full state is dropped and the pending count becomes (tail − head) mod length.
- R9: After reset all pointers, the pending count, the generation, both error flags, both enables and the base and length registers are 0. Writes to addresses 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register word address |
| reg_wr_data | input | 32 | Register write data |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_addr | output | 64 | Byte address of the descriptor at the head |
| fetch_ack | input | 1 | Fetch accepted; `fetch_word0` valid |
| fetch_word0 | input | 32 | First word of the fetched descriptor |
| tail_ptr | output | 24 | Tail index |
| head_ptr | output | 24 | Head index |
| curr_ptr | output | 24 | Index of the descriptor in execution |
| pend_cnt | output | 25 | Pending descriptor count |
| q_full | output | 1 | Ring is full |
| exp_gen | output | 2 | Expected wrap generation |
| err_ring_id | output | 1 | Sticky generation-tag mismatch flag |
| err_db_ovf | output | 1 | Sticky rejected-doorbell flag |

## Verification
The embedded assertions check four properties on every cycle:
- the pending count never climbs above an unchanged ring length;
- a rejected doorbell leaves the tail untouched;
- every accepted fetch steps the head by exactly one with wrap;
- the error flag, once set, stays set, and an unacknowledged request holds its level and address while no register write occurs.

Other behaviours depend on arithmetic across sequences of writes and fetches, so only the bench scenarios can show them. These include:
- the exact tail values after multi-descriptor doorbells;
- the full boundary and overflow rejection;
- the generation advancing over several wraps and a deliberate tag mismatch;
- the pending count recomputed after independent soft clears;
- ignored acknowledges and ignored register addresses.

// File: rtl/dring_pkg.sv
package dring_pkg;

   // register word addresses of the write port
   typedef enum logic [2:0] {
      RA_CFG     = 3'd0,
      RA_BASE_LO = 3'd1,
      RA_BASE_HI = 3'd2,
      RA_LEN     = 3'd3,
      RA_DBELL   = 3'd4,
      RA_SOFT    = 3'd5
   } dring_reg_e;

   // field positions software depends on
   localparam int CFG_PREF_BIT  = 16;
   localparam int CFG_SCHED_BIT = 17;
   localparam int SOFT_TAIL_BIT = 1;
   localparam int SOFT_HEAD_BIT = 2;
   localparam int SOFT_CUR_BIT  = 3;
   localparam int BASE_ALIGN    = 6;
   localparam int REG_DW        = 32;

endpackage

// File: rtl/dring_regs.sv
module dring_regs
   import dring_pkg::*;
#(
   parameter int PTR_W  = 24,
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [REG_DW-1:0] wr_data,
   output logic              cfg_pref,
   output logic              cfg_sched,
   output logic [ADDR_W-1:0] ring_base,
   output logic [PTR_W-1:0]  ring_len,
   output logic              len_wr,
   output logic              db_fire,
   output logic [PTR_W-1:0]  db_val,
   output logic              clr_tail,
   output logic              clr_head,
   output logic              clr_cur
);

   localparam int LO_W = REG_DW - BASE_ALIGN;

   logic            sel_cfg, sel_lo, sel_hi, sel_soft;
   logic [LO_W-1:0] base_lo_q;

   assign sel_cfg  = wr_en && (wr_addr == RA_CFG);
   assign sel_lo   = wr_en && (wr_addr == RA_BASE_LO);
   assign sel_hi   = wr_en && (wr_addr == RA_BASE_HI);
   assign len_wr   = wr_en && (wr_addr == RA_LEN);
   assign db_fire  = wr_en && (wr_addr == RA_DBELL);
   assign sel_soft = wr_en && (wr_addr == RA_SOFT);

   assign db_val   = wr_data[PTR_W-1:0];
   assign clr_tail = sel_soft && wr_data[SOFT_TAIL_BIT];
   assign clr_head = sel_soft && wr_data[SOFT_HEAD_BIT];
   assign clr_cur  = sel_soft && wr_data[SOFT_CUR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_pref  <= 1'b0;
         cfg_sched <= 1'b0;
         base_lo_q <= '0;
         ring_len  <= '0;
      end else begin
         if (sel_cfg) begin
            cfg_pref  <= wr_data[CFG_PREF_BIT];
            cfg_sched <= wr_data[CFG_SCHED_BIT];
         end
         if (sel_lo) base_lo_q <= wr_data[REG_DW-1:BASE_ALIGN];
         if (len_wr) ring_len  <= wr_data[PTR_W-1:0];
      end
   end

   generate
      if (ADDR_W > REG_DW) begin : g_wide
         logic [ADDR_W-REG_DW-1:0] base_hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      base_hi_q <= '0;
            else if (sel_hi) base_hi_q <= wr_data[ADDR_W-REG_DW-1:0];
         end
         assign ring_base = {base_hi_q, base_lo_q, {BASE_ALIGN{1'b0}}};
      end else begin : g_narrow
         logic unused_hi;
         assign unused_hi = sel_hi;
         assign ring_base = {base_lo_q, {BASE_ALIGN{1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/dring_fetch.sv
module dring_fetch #(
   parameter int PTR_W     = 24,
   parameter int ADDR_W    = 64,
   parameter int DESC_LOG2 = 4
) (
   input  logic              cfg_pref,
   input  logic              cfg_sched,
   input  logic [PTR_W:0]    pend,
   input  logic [PTR_W-1:0]  head,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic              fetch_ack,
   output logic              fetch_req,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic              fire
);

   logic [ADDR_W-1:0] head_off;

   assign head_off   = ADDR_W'(head) << DESC_LOG2;
   assign fetch_addr = ring_base + head_off;
   assign fetch_req  = cfg_pref && cfg_sched && (pend != '0);
   assign fire       = fetch_req && fetch_ack;

endmodule

// File: rtl/dring_ptrs.sv
module dring_ptrs #(
   parameter int PTR_W     = 24,
   parameter int GEN_W     = 2,
   parameter bit GEN_CHECK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PTR_W-1:0] ring_len,
   input  logic             len_wr,
   input  logic             db_fire,
   input  logic [PTR_W-1:0] db_val,
   input  logic             clr_tail,
   input  logic             clr_head,
   input  logic             clr_cur,
   input  logic             fire,
   input  logic [GEN_W-1:0] tag,
   output logic [PTR_W-1:0] tail_q,
   output logic [PTR_W-1:0] head_q,
   output logic [PTR_W-1:0] cur_q,
   output logic [PTR_W:0]   pend,
   output logic             full_q,
   output logic [GEN_W-1:0] gen_q,
   output logic             err_ring_id,
   output logic             err_db_ovf
);

   localparam int EW = PTR_W + 1;

   logic [EW-1:0]    len_x, pend_sum, tail_sum;
   logic [PTR_W-1:0] tail_nxt, head_inc;
   logic             db_ok, db_acc, head_wrap;

   assign len_x = {1'b0, ring_len};

   // pending count: full flag disambiguates tail == head
   always_comb begin
      if (full_q)               pend = len_x;
      else if (tail_q >= head_q) pend = {1'b0, tail_q} - {1'b0, head_q};
      else                      pend = {1'b0, tail_q} + len_x - {1'b0, head_q};
   end

   assign pend_sum = pend + {1'b0, db_val};
   assign db_ok    = (pend_sum <= len_x);
   assign db_acc   = db_fire && db_ok;

   assign tail_sum = {1'b0, tail_q} + {1'b0, db_val};
   assign tail_nxt = (tail_sum >= len_x) ? PTR_W'(tail_sum - len_x) : tail_sum[PTR_W-1:0];

   assign head_wrap = (({1'b0, head_q} + EW'(1)) == len_x);
   assign head_inc  = head_wrap ? '0 : head_q + PTR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tail_q     <= '0;
         head_q     <= '0;
         cur_q      <= '0;
         full_q     <= 1'b0;
         gen_q      <= '0;
         err_db_ovf <= 1'b0;
      end else begin
         if (clr_tail)    tail_q <= '0;
         else if (db_acc) tail_q <= tail_nxt;

         if (clr_head)  head_q <= '0;
         else if (fire) head_q <= head_inc;

         if (clr_cur)   cur_q <= '0;
         else if (fire) cur_q <= head_q;

         if (clr_tail || clr_head) full_q <= 1'b0;
         else if (fire)            full_q <= 1'b0;
         else if (db_acc && (db_val != '0) && (pend_sum == len_x)) full_q <= 1'b1;

         if (clr_head)               gen_q <= '0;
         else if (fire && head_wrap) gen_q <= gen_q + GEN_W'(1);

         if (db_fire && !db_ok) err_db_ovf <= 1'b1;
      end
   end

   generate
      if (GEN_CHECK) begin : g_tagchk
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    err_ring_id <= 1'b0;
            else if (fire && tag != gen_q) err_ring_id <= 1'b1;
         end
      end else begin : g_notag
         logic unused_tag;
         assign unused_tag  = ^tag;
         assign err_ring_id = 1'b0;
      end
   endgenerate

   // R6: pending stays within an unchanged ring length
   assert_pend_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend <= len_x) && !len_wr |=> pend <= len_x);

   // R3: a rejected doorbell leaves the tail where it was
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      db_fire && !db_ok |=> $stable(tail_q));

   // R5: each accepted fetch steps the head by one with wrap
   assert_head_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !clr_head |=>
         head_q == ((({1'b0, $past(head_q)} + EW'(1)) == {1'b0, $past(ring_len)})
                    ? '0 : $past(head_q) + PTR_W'(1)));

   // R7: the ring-identity error is sticky
   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_ring_id |=> err_ring_id);

endmodule

// File: rtl/dring_ctrl.sv
module dring_ctrl
   import dring_pkg::*;
#(
   parameter int PTR_W     = 24,
   parameter int ADDR_W    = 64,
   parameter int DESC_LOG2 = 4,
   parameter int GEN_W     = 2,
   parameter int TAG_LSB   = 24,
   parameter bit GEN_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [2:0]        reg_wr_addr,
   input  logic [31:0]       reg_wr_data,
   output logic              fetch_req,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_ack,
   input  logic [31:0]       fetch_word0,
   output logic [PTR_W-1:0]  tail_ptr,
   output logic [PTR_W-1:0]  head_ptr,
   output logic [PTR_W-1:0]  curr_ptr,
   output logic [PTR_W:0]    pend_cnt,
   output logic              q_full,
   output logic [GEN_W-1:0]  exp_gen,
   output logic              err_ring_id,
   output logic              err_db_ovf
);

   initial begin
      assert (PTR_W >= 2 && PTR_W <= 30) else $fatal(1, "PTR_W out of range");
      assert (ADDR_W >= REG_DW && ADDR_W <= 2 * REG_DW) else $fatal(1, "ADDR_W out of range");
      assert (DESC_LOG2 >= 0 && DESC_LOG2 <= BASE_ALIGN) else $fatal(1, "DESC_LOG2 out of range");
      assert (PTR_W + DESC_LOG2 <= ADDR_W) else $fatal(1, "ring does not fit address");
      assert (GEN_W >= 1 && TAG_LSB + GEN_W <= REG_DW) else $fatal(1, "tag field out of word");
   end

   logic              cfg_pref, cfg_sched, len_wr, db_fire, fire;
   logic              clr_tail, clr_head, clr_cur;
   logic [ADDR_W-1:0] ring_base;
   logic [PTR_W-1:0]  ring_len, db_val;
   logic [GEN_W-1:0]  tag;
   logic              unused_w0;

   assign tag       = fetch_word0[TAG_LSB +: GEN_W];
   assign unused_w0 = ^fetch_word0;

   dring_regs #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
      .cfg_pref(cfg_pref), .cfg_sched(cfg_sched),
      .ring_base(ring_base), .ring_len(ring_len), .len_wr(len_wr),
      .db_fire(db_fire), .db_val(db_val),
      .clr_tail(clr_tail), .clr_head(clr_head), .clr_cur(clr_cur)
   );

   dring_ptrs #(.PTR_W(PTR_W), .GEN_W(GEN_W), .GEN_CHECK(GEN_CHECK)) ptrs_i (
      .clk(clk), .rst_n(rst_n),
      .ring_len(ring_len), .len_wr(len_wr),
      .db_fire(db_fire), .db_val(db_val),
      .clr_tail(clr_tail), .clr_head(clr_head), .clr_cur(clr_cur),
      .fire(fire), .tag(tag),
      .tail_q(tail_ptr), .head_q(head_ptr), .cur_q(curr_ptr),
      .pend(pend_cnt), .full_q(q_full), .gen_q(exp_gen),
      .err_ring_id(err_ring_id), .err_db_ovf(err_db_ovf)
   );

   dring_fetch #(.PTR_W(PTR_W), .ADDR_W(ADDR_W), .DESC_LOG2(DESC_LOG2)) fetch_i (
      .cfg_pref(cfg_pref), .cfg_sched(cfg_sched),
      .pend(pend_cnt), .head(head_ptr), .ring_base(ring_base),
      .fetch_ack(fetch_ack),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fire(fire)
   );

   // R4: an unanswered request persists while no register is written
   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req && !fetch_ack && !reg_wr_en |=> fetch_req);

   // R2: the offered address does not move while waiting for acceptance
   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req && !fetch_ack && !reg_wr_en |=> $stable(fetch_addr));

endmodule

// File: tb/dring_ctrl_tb_top.sv
`timescale 1ns/100ps
module dring_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [2:0]  reg_wr_addr = '0;
   logic [31:0] reg_wr_data = '0;
   logic        fetch_ack = 1'b0;
   logic [31:0] fetch_word0 = '0;
   logic        fetch_req, q_full, err_ring_id, err_db_ovf;
   logic [63:0] fetch_addr;
   logic [23:0] tail_ptr, head_ptr, curr_ptr;
   logic [24:0] pend_cnt;
   logic [1:0]  exp_gen;

   int checks = 0, failures = 0, cyc = 0;
   bit ack_on = 0, bad_tag = 0, cmp_on = 1;
   logic [7:0] lfsr = 8'hA5;

   // reference state
   int m_tail, m_head, m_cur, m_cnt, m_len, m_gen;
   bit m_pref, m_sched, m_eid, m_eovf;
   logic [63:0] m_base;

   always #2.5 clk = ~clk;

   dring_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .fetch_ack(fetch_ack), .fetch_word0(fetch_word0),
      .tail_ptr(tail_ptr), .head_ptr(head_ptr), .curr_ptr(curr_ptr),
      .pend_cnt(pend_cnt), .q_full(q_full), .exp_gen(exp_gen),
      .err_ring_id(err_ring_id), .err_db_ovf(err_db_ovf)
   );

   function automatic bit m_req();
      return m_pref && m_sched && (m_cnt != 0);
   endfunction

   task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // reference model, updated on each rising edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_tail = 0; m_head = 0; m_cur = 0; m_cnt = 0; m_len = 0; m_gen = 0;
         m_pref = 0; m_sched = 0; m_eid = 0; m_eovf = 0; m_base = '0;
      end else begin
         int old_cnt, n;
         bit fire;
         old_cnt = m_cnt;
         fire = fetch_ack && m_req();
         if (fire) begin
            if (int'(fetch_word0[25:24]) != m_gen) m_eid = 1;
            m_cur = m_head;
            if (m_head + 1 == m_len) begin m_head = 0; m_gen = (m_gen + 1) % 4; end
            else m_head = m_head + 1;
            m_cnt = m_cnt - 1;
         end
         if (reg_wr_en) begin
            case (reg_wr_addr)
               3'd0: begin m_pref = reg_wr_data[16]; m_sched = reg_wr_data[17]; end
               3'd1: m_base[31:0] = {reg_wr_data[31:6], 6'b0};
               3'd2: m_base[63:32] = reg_wr_data;
               3'd3: m_len = int'(reg_wr_data[23:0]);
               3'd4: begin
                  n = int'(reg_wr_data[23:0]);
                  if (old_cnt + n <= m_len) begin
                     if (n > 0) m_tail = (m_tail + n) % m_len;
                     m_cnt = m_cnt + n;
                  end else m_eovf = 1;
               end
               3'd5: begin
                  if (reg_wr_data[1]) m_tail = 0;
                  if (reg_wr_data[2]) begin m_head = 0; m_gen = 0; end
                  if (reg_wr_data[3]) m_cur = 0;
                  if (reg_wr_data[1] || reg_wr_data[2])
                     m_cnt = (m_len == 0) ? 0 : (m_tail - m_head + m_len) % m_len;
               end
               default: ;
            endcase
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R1", "tail", 64'(tail_ptr), 64'(m_tail));
         chk("R5", "head", 64'(head_ptr), 64'(m_head));
         chk("R5", "curr", 64'(curr_ptr), 64'(m_cur));
         chk("R6", "pend", 64'(pend_cnt), 64'(m_cnt));
         chk("R6", "full", 64'(q_full), 64'(m_len != 0 && m_cnt == m_len));
         chk("R4", "req", 64'(fetch_req), 64'(m_req()));
         chk("R2", "addr", fetch_addr, m_base + (64'(m_head) << 4));
         chk("R7", "gen", 64'(exp_gen), 64'(m_gen));
         chk("R7", "err_id", 64'(err_ring_id), 64'(m_eid));
         chk("R3", "err_ovf", 64'(err_db_ovf), 64'(m_eovf));
      end
   end

   // acknowledge driver
   always @(negedge clk) begin
      logic [1:0] t;
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      t = bad_tag ? 2'(m_gen + 1) : 2'(m_gen);
      fetch_ack <= ack_on && lfsr[0];
      fetch_word0 <= {6'h2A, t, 24'h5A3C11};
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      idle(3);
      // R9: reset state
      chk("R9", "tail@rst", 64'(tail_ptr), 0);
      chk("R9", "pend@rst", 64'(pend_cnt), 0);
      chk("R9", "req@rst", 64'(fetch_req), 0);
      chk("R9", "addr@rst", fetch_addr, 0);
      rst_n = 1'b1;
      idle(2);

      wr(3'd3, 32'd5);
      wr(3'd1, 32'h1234_567F);
      wr(3'd2, 32'h0000_00A0);
      wr(3'd0, 32'h0001_0000);            // prefetch only
      wr(3'd4, 32'd3);
      chk("R1", "tail after +3", 64'(tail_ptr), 3);
      chk("R4", "req needs both enables", 64'(fetch_req), 0);
      wr(3'd0, 32'h0003_0000);
      chk("R4", "req enabled", 64'(fetch_req), 1);
      chk("R2", "aligned base", fetch_addr, 64'hA0_1234_5640);

      ack_on = 1; idle(30); ack_on = 0; idle(2);
      chk("R5", "drained", 64'(pend_cnt), 0);
      chk("R5", "curr last", 64'(curr_ptr), 2);

      wr(3'd4, 32'd4);                    // tail 3 -> 2, wraps
      chk("R1", "tail wraps", 64'(tail_ptr), 2);
      ack_on = 1; idle(30); ack_on = 0; idle(2);
      chk("R7", "gen after wrap", 64'(exp_gen), 1);
      chk("R5", "head at tail", 64'(head_ptr), 2);

      wr(3'd4, 32'd5);
      chk("R6", "full", 64'(q_full), 1);
      chk("R6", "pend full", 64'(pend_cnt), 5);
      wr(3'd4, 32'd1);
      chk("R3", "overflow ignored", 64'(tail_ptr), 2);
      chk("R3", "overflow flag", 64'(err_db_ovf), 1);
      wr(3'd4, 32'd0);
      chk("R1", "zero doorbell", 64'(tail_ptr), 2);
      wr(3'd7, 32'hFFFF_FFFF);
      wr(3'd6, 32'hFFFF_FFFF);
      chk("R9", "unused address", 64'(pend_cnt), 5);

      chk("R7", "no tag error yet", 64'(err_ring_id), 0);
      bad_tag = 1; ack_on = 1; idle(12); bad_tag = 0; idle(20); ack_on = 0; idle(2);
      chk("R7", "tag mismatch", 64'(err_ring_id), 1);

      wr(3'd4, 32'd3);                    // pending 3 (acks idle)
      wr(3'd5, 32'h0000_0002);            // tail clear
      chk("R8", "tail cleared", 64'(tail_ptr), 0);
      wr(3'd5, 32'h0000_0004);            // head clear
      chk("R8", "head cleared", 64'(head_ptr), 0);
      chk("R8", "gen cleared", 64'(exp_gen), 0);
      chk("R8", "pend after clears", 64'(pend_cnt), 0);
      wr(3'd5, 32'h0000_0008);
      chk("R8", "curr cleared", 64'(curr_ptr), 0);

      // doorbells under concurrent acknowledges
      ack_on = 1;
      for (int i = 0; i < 40; i++) begin
         wr(3'd4, 32'(i % 4));
         idle(i % 3);
      end
      wr(3'd5, 32'h0000_0006);            // clears under traffic
      wr(3'd3, 32'd3);
      for (int i = 0; i < 30; i++) wr(3'd4, 32'(1 + (i % 2)));
      idle(20); ack_on = 0;
      wr(3'd0, 32'h0002_0000);
      ack_on = 1; wr(3'd4, 32'd1); idle(5); ack_on = 0;
      chk("R5", "ack ignored without req", 64'(fetch_req), 0);
      idle(2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule